// File: doc/BRIEF.md
# Calendar Timekeeper with Periodic Tick

This block keeps a running calendar (seconds, minutes, hours, weekday, day of month, month and a full binary year) and moves it forward by one second whenever its once-per-second enable is high. Every carry out of one field into the next happens in the same clock cycle. Month lengths follow the Gregorian calendar, so February gains a day in leap years.

A second, independent part counts enable pulses from the 32.768 kHz timebase. It raises a sticky interrupt flag at an interval picked by a 4-bit rate code. Software acknowledges the flag with a one-cycle strobe. A write strobe with a field selector and a data bus loads any single calendar field directly.

Top module: `rtc_calendar_core`

## Requirements
- R1: On each cycle with `sec_tick` high and `wr_en` low, the seconds field increments. A seconds value reaching 60 becomes 0 and carries into minutes. Minutes wrap the same way at 60 and carry into hours. Hours wrap at 24 and produce a day rollover. With `sec_tick` low and `wr_en` low, no calendar field changes.
- R2: The weekday field (0..6) increments on every day rollover, and 6 wraps to 0.
- R3: On a day rollover, day of month increments. If the result exceeds the length of the current month, day becomes 1 and the month advances. Month lengths indexed by month 0..11 are 31,28,31,30,31,30,31,31,30,31,30,31, and any month value of 12 or above counts as 31.
- R4: The month field is zero-based. When an advance from 11 is due, it becomes 0 and the year field increments.
- R5: February (month 1) has 29 days when the year is divisible by 4 and is not a century, or is divisible by 400. Otherwise it has 28.
- R6: A day-of-month value of 0 becomes 1 on the next day rollover, and the month does not change.
- R7: The rate code picks the interval. Codes 1 and 2 are first raised by 7. The flag then sets after 2^(code-1) pulses of `base_tick` counted from an enabled start, and again after every further such interval.
- R8: With `per_en` low or a rate code of 0, the interval counter is held at zero and the flag is never set.
- R9: `per_flag` stays high until a cycle with `per_ack` high clears it. If a set and an acknowledge fall in the same cycle, the flag ends high.
- R10: `wr_en` loads `wr_data` into the field named by `wr_sel` (0 seconds, 1 minutes, 2 hours, 3 weekday, 4 day of month, 5 month, 6 year), truncated to the field width. A `wr_sel` of 7 changes nothing. A write suppresses any second advance in the same cycle, for all fields.
- R11: Synchronous reset gives 00:00:00, weekday 0, day 1, month 0, year `RESET_YEAR` and a low flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_tick | input | 1 | Once-per-second advance enable |
| base_tick | input | 1 | 32.768 kHz timebase enable pulse |
| wr_en | input | 1 | Field write strobe |
| wr_sel | input | 3 | Field selector for the write |
| wr_data | input | 12 | Write data, low bits used for narrow fields |
| rate_code | input | 4 | Periodic interval code |
| per_en | input | 1 | Periodic tick enable |
| per_ack | input | 1 | Flag acknowledge strobe |
| sec_o | output | 6 | Seconds |
| min_o | output | 6 | Minutes |
| hour_o | output | 5 | Hours |
| wday_o | output | 3 | Weekday |
| mday_o | output | 5 | Day of month |
| mon_o | output | 4 | Month, zero-based |
| year_o | output | 12 | Year, binary |
| per_flag | output | 1 | Sticky periodic interrupt flag |

## Verification
Every calendar field is a port, so a corrupted carry or month length shows on the outputs in the cycle right after the tick that triggered it. A bad day or month limit is visible one cycle after the rollover at the end of that month. A fault in the interval counter appears only when the flag rises, up to one full interval late. At the longest code that is 16384 timebase pulses, so the slow codes are run to completion. The reference model is compared on every clock, which catches a fault at its first visible cycle.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    localparam int SEC_W  = 6;
    localparam int MIN_W  = 6;
    localparam int HOUR_W = 5;
    localparam int WDAY_W = 3;
    localparam int MDAY_W = 5;
    localparam int MON_W  = 4;
    localparam int YEAR_W = 12;
    localparam int RATE_W = 4;
    localparam int CNT_W  = (1 << RATE_W) - 2;

    localparam int SEC_MOD  = 60;
    localparam int MIN_MOD  = 60;
    localparam int HOUR_MOD = 24;
    localparam int WDAY_MOD = 7;
    localparam int MON_MOD  = 12;
    localparam int LOW_CODE_BOOST = 7;

    typedef enum logic [2:0] {
        FS_SEC  = 3'd0,
        FS_MIN  = 3'd1,
        FS_HOUR = 3'd2,
        FS_WDAY = 3'd3,
        FS_MDAY = 3'd4,
        FS_MON  = 3'd5,
        FS_YEAR = 3'd6,
        FS_NONE = 3'd7
    } field_sel_e;

    typedef struct packed {
        logic [SEC_W-1:0]  sec;
        logic [MIN_W-1:0]  min;
        logic [HOUR_W-1:0] hour;
    } tod_t;

    typedef struct packed {
        logic [WDAY_W-1:0] wday;
        logic [MDAY_W-1:0] mday;
        logic [MON_W-1:0]  mon;
        logic [YEAR_W-1:0] year;
    } date_t;

    function automatic logic is_leap(input logic [YEAR_W-1:0] y);
        return ((y % YEAR_W'(4)) == '0) &&
               (((y % YEAR_W'(100)) != '0) || ((y % YEAR_W'(400)) == '0));
    endfunction

    function automatic logic [MDAY_W:0] month_len(input logic [MON_W-1:0] m,
                                                  input logic leap);
        case (m)
            MON_W'(1):                                  return leap ? (MDAY_W+1)'(29) : (MDAY_W+1)'(28);
            MON_W'(3), MON_W'(5), MON_W'(8), MON_W'(10): return (MDAY_W+1)'(30);
            default:                                    return (MDAY_W+1)'(31);
        endcase
    endfunction

    function automatic logic [RATE_W-1:0] eff_rate(input logic [RATE_W-1:0] code);
        if (code == RATE_W'(1) || code == RATE_W'(2))
            return code + RATE_W'(LOW_CODE_BOOST);
        return code;
    endfunction
endpackage

// File: rtl/rtc_tod_chain.sv
module rtc_tod_chain
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              adv,
    input  logic              wr_en,
    input  logic [2:0]        wr_sel,
    input  logic [YEAR_W-1:0] wr_data,
    output tod_t              tod,
    output logic              day_carry
);
    tod_t q;
    logic [SEC_W:0]  sec_p1;
    logic [MIN_W:0]  min_p1;
    logic [HOUR_W:0] hour_p1;
    logic wrap_s, wrap_m, wrap_h;

    always_comb begin
        sec_p1  = {1'b0, q.sec}  + (SEC_W+1)'(1);
        min_p1  = {1'b0, q.min}  + (MIN_W+1)'(1);
        hour_p1 = {1'b0, q.hour} + (HOUR_W+1)'(1);
        wrap_s  = sec_p1  >= (SEC_W+1)'(SEC_MOD);
        wrap_m  = min_p1  >= (MIN_W+1)'(MIN_MOD);
        wrap_h  = hour_p1 >= (HOUR_W+1)'(HOUR_MOD);
        day_carry = adv && wrap_s && wrap_m && wrap_h;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (wr_en) begin
            case (field_sel_e'(wr_sel))
                FS_SEC:  q.sec  <= wr_data[SEC_W-1:0];
                FS_MIN:  q.min  <= wr_data[MIN_W-1:0];
                FS_HOUR: q.hour <= wr_data[HOUR_W-1:0];
                default: ;
            endcase
        end else if (adv) begin
            q.sec <= wrap_s ? '0 : sec_p1[SEC_W-1:0];
            if (wrap_s) begin
                q.min <= wrap_m ? '0 : min_p1[MIN_W-1:0];
                if (wrap_m)
                    q.hour <= wrap_h ? '0 : hour_p1[HOUR_W-1:0];
            end
        end
    end

    assign tod = q;
endmodule

// File: rtl/rtc_date_chain.sv
module rtc_date_chain
    import rtc_pkg::*;
#(
    parameter int RESET_YEAR = 2000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              day_inc,
    input  logic              wr_en,
    input  logic [2:0]        wr_sel,
    input  logic [YEAR_W-1:0] wr_data,
    output date_t             date
);
    date_t q;
    logic [WDAY_W:0] wday_p1;
    logic [MDAY_W:0] mday_p1;
    logic [MON_W:0]  mon_p1;
    logic [MDAY_W:0] len;
    logic wrap_w, wrap_d, wrap_mo;

    always_comb begin
        wday_p1 = {1'b0, q.wday} + (WDAY_W+1)'(1);
        mday_p1 = {1'b0, q.mday} + (MDAY_W+1)'(1);
        mon_p1  = {1'b0, q.mon}  + (MON_W+1)'(1);
        len     = month_len(q.mon, is_leap(q.year));
        wrap_w  = wday_p1 >= (WDAY_W+1)'(WDAY_MOD);
        wrap_d  = mday_p1 > len;
        wrap_mo = mon_p1 >= (MON_W+1)'(MON_MOD);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q.wday <= '0;
            q.mday <= MDAY_W'(1);
            q.mon  <= '0;
            q.year <= YEAR_W'(RESET_YEAR);
        end else if (wr_en) begin
            case (field_sel_e'(wr_sel))
                FS_WDAY: q.wday <= wr_data[WDAY_W-1:0];
                FS_MDAY: q.mday <= wr_data[MDAY_W-1:0];
                FS_MON:  q.mon  <= wr_data[MON_W-1:0];
                FS_YEAR: q.year <= wr_data;
                default: ;
            endcase
        end else if (day_inc) begin
            q.wday <= wrap_w ? '0 : wday_p1[WDAY_W-1:0];
            q.mday <= wrap_d ? MDAY_W'(1) : mday_p1[MDAY_W-1:0];
            if (wrap_d) begin
                q.mon <= wrap_mo ? '0 : mon_p1[MON_W-1:0];
                if (wrap_mo)
                    q.year <= q.year + YEAR_W'(1);
            end
        end
    end

    assign date = q;
endmodule

// File: rtl/rtc_periodic_div.sv
module rtc_periodic_div
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic              enable,
    input  logic [RATE_W-1:0] rate,
    input  logic              ack,
    output logic              flag
);
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  lim;
    logic [RATE_W-1:0] eff;
    logic              active, fire;

    always_comb begin
        eff    = eff_rate(rate);
        lim    = CNT_W'((32'd1 << (eff - RATE_W'(1))) - 32'd1);
        active = enable && (rate != '0);
        fire   = active && tick_en && (cnt >= lim);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            flag <= 1'b0;
        end else begin
            if (!active)
                cnt <= '0;
            else if (tick_en)
                cnt <= fire ? '0 : cnt + CNT_W'(1);
            if (fire)
                flag <= 1'b1;
            else if (ack)
                flag <= 1'b0;
        end
    end
endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
    import rtc_pkg::*;
#(
    parameter int RESET_YEAR = 2000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sec_tick,
    input  logic              base_tick,
    input  logic              wr_en,
    input  logic [2:0]        wr_sel,
    input  logic [YEAR_W-1:0] wr_data,
    input  logic [RATE_W-1:0] rate_code,
    input  logic              per_en,
    input  logic              per_ack,
    output logic [SEC_W-1:0]  sec_o,
    output logic [MIN_W-1:0]  min_o,
    output logic [HOUR_W-1:0] hour_o,
    output logic [WDAY_W-1:0] wday_o,
    output logic [MDAY_W-1:0] mday_o,
    output logic [MON_W-1:0]  mon_o,
    output logic [YEAR_W-1:0] year_o,
    output logic              per_flag
);
    tod_t  tod;
    date_t date;
    logic  day_carry;

    rtc_tod_chain u_tod (
        .clk(clk), .rst(rst), .adv(sec_tick && !wr_en), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .tod(tod), .day_carry(day_carry)
    );

    rtc_date_chain #(.RESET_YEAR(RESET_YEAR)) u_date (
        .clk(clk), .rst(rst), .day_inc(day_carry), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .date(date)
    );

    rtc_periodic_div u_per (
        .clk(clk), .rst(rst), .tick_en(base_tick), .enable(per_en),
        .rate(rate_code), .ack(per_ack), .flag(per_flag)
    );

    assign sec_o  = tod.sec;
    assign min_o  = tod.min;
    assign hour_o = tod.hour;
    assign wday_o = date.wday;
    assign mday_o = date.mday;
    assign mon_o  = date.mon;
    assign year_o = date.year;
endmodule

// File: rtl/rtc_calendar_core_chk.sv
module rtc_calendar_core_chk
    import rtc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              sec_tick,
    input logic              wr_en,
    input logic [2:0]        wr_sel,
    input logic [YEAR_W-1:0] wr_data,
    input logic [RATE_W-1:0] rate_code,
    input logic              per_en,
    input logic              per_ack,
    input logic [SEC_W-1:0]  sec_o,
    input logic [MIN_W-1:0]  min_o,
    input logic [HOUR_W-1:0] hour_o,
    input logic [WDAY_W-1:0] wday_o,
    input logic [MDAY_W-1:0] mday_o,
    input logic [MON_W-1:0]  mon_o,
    input logic [YEAR_W-1:0] year_o,
    input logic              per_flag
);
    logic last_sec;
    assign last_sec = sec_tick && !wr_en && sec_o == SEC_W'(59) &&
                      min_o == MIN_W'(59) && hour_o == HOUR_W'(23);

    p_sec_step_r1: assert property (@(posedge clk) disable iff (rst)
        (sec_tick && !wr_en && sec_o < SEC_W'(59)) |=> sec_o == $past(sec_o) + SEC_W'(1));

    p_sec_wrap_r1: assert property (@(posedge clk) disable iff (rst)
        (sec_tick && !wr_en && sec_o == SEC_W'(59) && min_o < MIN_W'(59))
        |=> (sec_o == '0 && min_o == $past(min_o) + MIN_W'(1)));

    p_hold_r1: assert property (@(posedge clk) disable iff (rst)
        (!sec_tick && !wr_en) |=> ($stable(sec_o) && $stable(min_o) && $stable(hour_o) &&
                                   $stable(wday_o) && $stable(mday_o) && $stable(mon_o) &&
                                   $stable(year_o)));

    p_wday_wrap_r2: assert property (@(posedge clk) disable iff (rst)
        (last_sec && wday_o == WDAY_W'(6)) |=> wday_o == '0);

    p_mday_nonzero_r6: assert property (@(posedge clk) disable iff (rst)
        last_sec |=> mday_o != '0);

    p_mon_range_r4: assert property (@(posedge clk) disable iff (rst)
        (last_sec && mon_o < MON_W'(12)) |=> mon_o < MON_W'(12));

    p_write_sec_r10: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == 3'd0) |=> sec_o == $past(wr_data[SEC_W-1:0]));

    p_write_none_r10: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == 3'd7) |=> ($stable(sec_o) && $stable(mday_o) && $stable(year_o)));

    p_flag_off_r8: assert property (@(posedge clk) disable iff (rst)
        ((!per_en || rate_code == '0) && !per_flag) |=> !per_flag);

    p_flag_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (per_flag && !per_ack) |=> per_flag);
endmodule

bind rtc_calendar_core rtc_calendar_core_chk u_chk (
    .clk(clk), .rst(rst), .sec_tick(sec_tick), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rate_code(rate_code), .per_en(per_en), .per_ack(per_ack),
    .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .wday_o(wday_o),
    .mday_o(mday_o), .mon_o(mon_o), .year_o(year_o), .per_flag(per_flag)
);

// File: tb/sim_rtc_calendar_core.sv
`timescale 1ns/1ps
module sim_rtc_calendar_core;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sec_tick = 1'b0, base_tick = 1'b0, wr_en = 1'b0;
    logic [2:0]  wr_sel = 3'd0;
    logic [11:0] wr_data = 12'd0;
    logic [3:0]  rate_code = 4'd0;
    logic        per_en = 1'b0, per_ack = 1'b0;
    logic [5:0]  sec_o, min_o;
    logic [4:0]  hour_o, mday_o;
    logic [2:0]  wday_o;
    logic [3:0]  mon_o;
    logic [11:0] year_o;
    logic        per_flag;

    rtc_calendar_core #(.RESET_YEAR(2000)) u0 (
        .clk(clk), .rst(rst), .sec_tick(sec_tick), .base_tick(base_tick),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .rate_code(rate_code),
        .per_en(per_en), .per_ack(per_ack), .sec_o(sec_o), .min_o(min_o),
        .hour_o(hour_o), .wday_o(wday_o), .mday_o(mday_o), .mon_o(mon_o),
        .year_o(year_o), .per_flag(per_flag)
    );

    always #10 clk = ~clk;

    int checks = 0, fails = 0, cyc = 0;
    bit live = 0, done = 0;

    // reference model state
    int m_sec, m_min, m_hour, m_wday, m_mday, m_mon, m_year, p_cnt;
    bit m_flag;

    function automatic bit leap_f(int y);
        return (y % 4 == 0) && ((y % 100 != 0) || (y % 400 == 0));
    endfunction

    function automatic int mlen_f(int m, int y);
        if (m == 1) return leap_f(y) ? 29 : 28;
        if (m == 3 || m == 5 || m == 8 || m == 10) return 30;
        return 31;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    task automatic finish_up();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            m_sec = 0; m_min = 0; m_hour = 0; m_wday = 0; m_mday = 1; m_mon = 0;
            m_year = 2000; p_cnt = 0; m_flag = 0;
        end else begin
            if (wr_en) begin
                case (wr_sel)
                    3'd0: m_sec  = wr_data % 64;
                    3'd1: m_min  = wr_data % 64;
                    3'd2: m_hour = wr_data % 32;
                    3'd3: m_wday = wr_data % 8;
                    3'd4: m_mday = wr_data % 32;
                    3'd5: m_mon  = wr_data % 16;
                    3'd6: m_year = int'(wr_data);
                    default: ;
                endcase
            end else if (sec_tick) begin
                m_sec++;
                if (m_sec >= 60) begin
                    m_sec = 0; m_min++;
                    if (m_min >= 60) begin
                        m_min = 0; m_hour++;
                        if (m_hour >= 24) begin
                            m_hour = 0;
                            m_wday = (m_wday + 1 >= 7) ? 0 : m_wday + 1;
                            m_mday++;
                            if (m_mday > mlen_f(m_mon, m_year)) begin
                                m_mday = 1; m_mon++;
                                if (m_mon >= 12) begin
                                    m_mon = 0; m_year = (m_year + 1) % 4096;
                                end
                            end
                        end
                    end
                end
            end
            begin
                int code, ival;
                bit setev;
                code = (rate_code == 1 || rate_code == 2) ? rate_code + 7 : rate_code;
                ival = (code == 0) ? 0 : (1 << (code - 1));
                setev = 0;
                if (!per_en || rate_code == 0) p_cnt = 0;
                else if (base_tick) begin
                    if (p_cnt + 1 >= ival) begin p_cnt = 0; setev = 1; end
                    else p_cnt++;
                end
                if (per_ack) m_flag = 0;
                if (setev) m_flag = 1;
            end
        end
        if (cyc >= 190000 && !done) begin
            checks++; fails++;
            $display("FAIL watchdog all requirements actual=timeout expected=completion");
            finish_up();
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (live) begin
            chk(sec_o == m_sec, "R1 sec", sec_o, m_sec);
            chk(min_o == m_min, "R1 min", min_o, m_min);
            chk(hour_o == m_hour, "R1 hour", hour_o, m_hour);
            chk(wday_o == m_wday, "R2 wday", wday_o, m_wday);
            chk(mday_o == m_mday, "R3 mday", mday_o, m_mday);
            chk(mon_o == m_mon, "R4 mon", mon_o, m_mon);
            chk(year_o == m_year, "R4 year", year_o, m_year);
            chk(per_flag == m_flag, "R9 flag", per_flag, m_flag);
        end
    end

    task automatic wr(input int sel, input int val);
        @(negedge clk);
        wr_en = 1; wr_sel = 3'(sel); wr_data = 12'(val);
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic set_cal(input int s, input int mi, input int h, input int wd,
                           input int md, input int mo, input int y);
        wr(0, s); wr(1, mi); wr(2, h); wr(3, wd); wr(4, md); wr(5, mo); wr(6, y);
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        sec_tick = 1;
        repeat (n) @(negedge clk);
        sec_tick = 0;
    endtask

    task automatic clear_flag();
        @(negedge clk);
        per_en = 0; per_ack = 1;
        @(negedge clk);
        per_ack = 0;
    endtask

    task automatic run_rate(input int code, input int interval, input string tag);
        clear_flag();
        rate_code = 4'(code); per_en = 1; base_tick = 1;
        repeat (interval - 1) @(negedge clk);
        chk(per_flag == 0, tag, per_flag, 0);
        @(negedge clk);
        chk(per_flag == 1, tag, per_flag, 1);
        base_tick = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        live = 1;
        // R11 reset state
        chk(sec_o == 0 && min_o == 0 && hour_o == 0, "R11 time", sec_o + min_o + hour_o, 0);
        chk(mday_o == 1 && mon_o == 0 && wday_o == 0, "R11 date", mday_o, 1);
        chk(year_o == 2000 && per_flag == 0, "R11 year", year_o, 2000);

        // R1 ordinary counting
        ticks(75);
        chk(sec_o == 15 && min_o == 1, "R1 count", sec_o, 15);

        // R3 R5 non-leap February, R2 weekday wrap
        set_cal(50, 59, 23, 6, 28, 1, 2023);
        ticks(10);
        chk(mday_o == 1 && mon_o == 2, "R5 feb 2023", mday_o, 1);
        chk(wday_o == 0, "R2 wday wrap", wday_o, 0);
        chk(hour_o == 0 && min_o == 0 && sec_o == 0, "R1 day wrap", hour_o, 0);

        // R5 leap years
        set_cal(59, 59, 23, 2, 28, 1, 2024);
        ticks(1);
        chk(mday_o == 29 && mon_o == 1, "R5 leap 2024", mday_o, 29);
        set_cal(59, 59, 23, 2, 28, 1, 1900);
        ticks(1);
        chk(mday_o == 1 && mon_o == 2, "R5 century 1900", mday_o, 1);
        set_cal(59, 59, 23, 2, 28, 1, 2000);
        ticks(1);
        chk(mday_o == 29, "R5 400 year 2000", mday_o, 29);

        // R3 30-day month
        set_cal(59, 59, 23, 3, 30, 3, 2021);
        ticks(1);
        chk(mday_o == 1 && mon_o == 4, "R3 april end", mon_o, 4);

        // R4 year rollover
        set_cal(59, 59, 23, 5, 31, 11, 2099);
        ticks(1);
        chk(mon_o == 0 && year_o == 2100 && mday_o == 1, "R4 new year", year_o, 2100);

        // R6 zero day
        set_cal(59, 59, 23, 1, 0, 6, 2022);
        ticks(1);
        chk(mday_o == 1 && mon_o == 6, "R6 zero day", mday_o, 1);

        // R10 selector 7 and write over tick
        set_cal(10, 20, 5, 4, 12, 8, 2030);
        wr(7, 33);
        chk(sec_o == 10 && min_o == 20 && year_o == 2030, "R10 sel7 ignored", sec_o, 10);
        @(negedge clk);
        wr_en = 1; wr_sel = 3'd1; wr_data = 12'd5; sec_tick = 1;
        @(negedge clk);
        wr_en = 0; sec_tick = 0;
        chk(min_o == 5 && sec_o == 10, "R10 write wins", sec_o, 10);
        wr(0, 12'hFFF);
        chk(sec_o == 63, "R10 truncation", sec_o, 63);

        // R7 intervals
        run_rate(3, 4, "R7 code3");
        run_rate(1, 128, "R7 code1");
        run_rate(2, 256, "R7 code2");
        run_rate(15, 16384, "R7 code15");

        // R9 sticky
        per_en = 0;
        repeat (5) @(negedge clk);
        chk(per_flag == 1, "R9 sticky", per_flag, 1);
        clear_flag();
        chk(per_flag == 0, "R9 ack clears", per_flag, 0);

        // R8 disabled cases
        rate_code = 0; per_en = 1; base_tick = 1;
        repeat (300) @(negedge clk);
        chk(per_flag == 0, "R8 code0", per_flag, 0);
        rate_code = 3; per_en = 0;
        repeat (50) @(negedge clk);
        chk(per_flag == 0, "R8 disabled", per_flag, 0);

        // R9 set beats ack
        per_ack = 1; per_en = 1;
        repeat (4) @(negedge clk);
        chk(per_flag == 1, "R9 set wins", per_flag, 1);
        @(negedge clk);
        chk(per_flag == 0, "R9 ack after", per_flag, 0);
        per_ack = 0;

        // mixed pattern
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            base_tick = (i % 3) != 0;
            per_ack = (i % 11) == 0;
            sec_tick = (i % 2) == 0;
            rate_code = (i < 200) ? 4'd3 : 4'd4;
        end
        sec_tick = 0; base_tick = 0; per_ack = 0;
        @(negedge clk);
        done = 1;
        finish_up();
    end
endmodule